// File: doc/BRIEF.md
# Variable-Length Serial Converter Port

This block models the device side of a converter's serial port in synthesizable form. A controller lowers a select line, clocks eight instruction bits in on the data input with a serial clock, and at the same time reads the previous conversion result on the data output. An instruction either starts a conversion, choosing a channel and an output format, or only changes the configuration: sign bit on or off, or acquisition time. A configuration instruction never starts a conversion. The conversion itself is a counter-based stand-in. After a fixed delay it latches a value made from the channel and a sequence number.

The data word is 12 or 16 bits, MSB-first or LSB-first, with an optional leading sign bit. A frame is therefore 12, 13, 16 or 17 serial clocks long. The port latches that length at the start of each frame, from the format and sign state left by earlier instructions. When the select line stays low, frames are delimited only by this count, and a frame with the wrong count sets a sticky desync flag. When the select line is strobed, raising it ends the frame at once. The port serves as the stand-in device when the sequencer that drives it is verified.

The inputs are sampled on the system clock. A serial clock edge is taken as a low-to-high change of `sclk` seen between two system clocks.

Top module: `vlsp_port`

## Requirements
- R1: After reset, `eoc` is 1, `desync` is 0 and `do_o` is 0. The sign bit is on, the format is 12-bit MSB-first and the acquisition code is 1 (10 clocks). The stored result is zero, so the first frame is 13 clocks long and shifts out all zeros.
- R2: While `cs_n` is low, each rising `sclk` captures one `di` bit. The first eight bits of a frame form the instruction, first bit = bit 7. `do_o` shows a frame's first bit from the frame start and advances one bit after each rising `sclk`.
- R3: An instruction with bit 7 = 1 starts a conversion: bit 6 selects 16-bit format, bit 5 selects LSB-first and bits 4:2 give the channel. `eoc` goes low on the clock after the eighth rising `sclk` and stays low for exactly A + CONV_CYCLES clocks, where A is 6, 10, 18 or 34 for acquisition codes 0 to 3. `do_o` is 0 while `eoc` is low.
- R4: When a conversion ends, the result is latched. The magnitude is {channel, low 9 bits of the count of conversions started since reset} and the sign bit is bit 0 of that count. The word sent is an optional sign bit first, then the data field. For MSB-first, the 16-bit field is the magnitude zero-extended and sent MSB-first, and the 12-bit field is the magnitude sent MSB-first. For LSB-first, magnitude bit 0 is sent first, followed in the 16-bit format by four zeros.
- R5: With `cs_n` held low, each frame is exactly (16 if 16-bit format else 12) + (1 if sign on) rising `sclk` edges. The length is taken at frame start, so a format or sign change made inside a frame applies from the next frame.
- R6: An instruction with bit 7 = 0 does not start a conversion, and `eoc` stays 1. Bits 6:4 = 001 turn the sign bit on, 010 turn it off, and 100 set the acquisition code from bits 1:0. Other codes change nothing. The next frame carries the most recent result.
- R7: If `cs_n` rises part-way through a frame that followed at least one count-delimited frame in the same low period, `desync` goes to 1 and stays there until reset. A frame that ends at its length boundary leaves it at 0.
- R8: A rising `cs_n` ends the frame, and the next fall starts a new frame at bit 0. A frame with fewer than eight rising `sclk` edges executes nothing. `do_o` is 0 while `cs_n` is high.
- R9: A frame that starts in the clock where a conversion completes shifts out the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock, sampled on clk |
| di | input | 1 | Serial instruction input |
| do_o | output | 1 | Serial data output |
| eoc | output | 1 | High when no conversion is running |
| desync | output | 1 | Sticky frame-count error flag |

## Verification
Two functions can fall in the same clock: the end of a conversion, which latches the result, and the start of a frame, which loads the output shift register. The bench provokes this with an eight-bit strobed conversion frame. It raises `cs_n` and then lowers it again so that the falling select is seen exactly A + CONV_CYCLES clocks after the eighth rising `sclk`. It then requires the whole following frame to carry the new result rather than the old one. Around this case the bench sweeps every format and sign combination and every acquisition code in count-delimited frames, and checks each frame's bits against a word assembled independently, bit by bit.

// File: rtl/vlsp_pkg.sv
package vlsp_pkg;
   localparam int ACQ_MAX = 34;
   localparam logic [2:0] OP_SIGN_ON  = 3'b001;
   localparam logic [2:0] OP_SIGN_OFF = 3'b010;
   localparam logic [2:0] OP_ACQ      = 3'b100;

   typedef struct packed {
      logic wide;
      logic lsb;
      logic sign_on;
   } fmt_t;

   function automatic int acq_clocks(input logic [1:0] code);
      return (4 << code) + 2;
   endfunction
endpackage

// File: rtl/vlsp_frame.sv
module vlsp_frame #(
   parameter int LEN_W   = 5,
   parameter int RST_LEN = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic             di,
   input  logic [LEN_W-1:0] len_in,
   output logic             load,
   output logic             sclk_rise,
   output logic             instr_valid,
   output logic [7:0]       instr,
   output logic             desync,
   output logic [LEN_W-1:0] cur_len
);
   logic             cs_q, sclk_q, cont, wrap, cs_fall, cs_rise;
   logic [LEN_W-1:0] cnt;
   logic [6:0]       ishift;

   assign cs_fall     = cs_q & ~cs_n;
   assign cs_rise     = ~cs_q & cs_n;
   assign sclk_rise   = ~cs_n & sclk & ~sclk_q;
   assign wrap        = sclk_rise && (cnt == cur_len - LEN_W'(1));
   assign load        = cs_fall | wrap;
   assign instr_valid = sclk_rise && (cnt == LEN_W'(7));
   assign instr       = {ishift, di};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q    <= 1'b1;
         sclk_q  <= 1'b0;
         cnt     <= '0;
         cont    <= 1'b0;
         desync  <= 1'b0;
         cur_len <= LEN_W'(RST_LEN);
         ishift  <= '0;
      end else begin
         cs_q   <= cs_n;
         sclk_q <= sclk;
         if (cs_fall) begin
            cnt     <= '0;
            cur_len <= len_in;
            cont    <= 1'b0;
         end else if (cs_rise) begin
            if (cont && cnt != '0) desync <= 1'b1;
            cnt  <= '0;
            cont <= 1'b0;
         end else if (sclk_rise) begin
            ishift <= {ishift[5:0], di};
            if (wrap) begin
               cnt     <= '0;
               cur_len <= len_in;
               cont    <= 1'b1;
            end else begin
               cnt <= cnt + LEN_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/vlsp_ctrl.sv
module vlsp_ctrl
   import vlsp_pkg::*;
#(
   parameter int MAG_W       = 12,
   parameter int EXT_W       = 4,
   parameter int CH_W        = 3,
   parameter int CONV_CYCLES = 20,
   parameter int LEN_W       = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             instr_valid,
   input  logic [7:0]       instr,
   output logic             eoc,
   output fmt_t             fmt,
   output logic [MAG_W-1:0] res_mag,
   output logic             res_sgn,
   output logic [LEN_W-1:0] len_next
);
   localparam int SEQ_W = MAG_W - CH_W;
   localparam int FLD_W = MAG_W + EXT_W;
   localparam int TMR_W = $clog2(ACQ_MAX + CONV_CYCLES + 1);

   logic [1:0]       acq;
   logic [CH_W-1:0]  chan;
   logic [SEQ_W-1:0] seq;
   logic             busy, done, sgn_q;
   logic [TMR_W-1:0] timer;
   logic [MAG_W-1:0] mag_q;

   assign done     = busy && (timer == '0);
   assign eoc      = ~busy;
   assign res_mag  = done ? {chan, seq} : mag_q;
   assign res_sgn  = done ? seq[0] : sgn_q;
   assign len_next = LEN_W'(fmt.wide ? FLD_W : MAG_W) + LEN_W'(fmt.sign_on);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt   <= '{wide: 1'b0, lsb: 1'b0, sign_on: 1'b1};
         acq   <= 2'd1;
         chan  <= '0;
         seq   <= '0;
         busy  <= 1'b0;
         timer <= '0;
         mag_q <= '0;
         sgn_q <= 1'b0;
      end else begin
         if (done) begin
            busy  <= 1'b0;
            mag_q <= {chan, seq};
            sgn_q <= seq[0];
         end else if (busy) begin
            timer <= timer - TMR_W'(1);
         end
         if (instr_valid) begin
            if (instr[7]) begin
               fmt.wide <= instr[6];
               fmt.lsb  <= instr[5];
               chan     <= instr[4:2];
               seq      <= seq + SEQ_W'(1);
               busy     <= 1'b1;
               timer    <= TMR_W'(acq_clocks(acq) + CONV_CYCLES - 1);
            end else begin
               case (instr[6:4])
                  OP_SIGN_ON:  fmt.sign_on <= 1'b1;
                  OP_SIGN_OFF: fmt.sign_on <= 1'b0;
                  OP_ACQ:      acq <= instr[1:0];
                  default:     ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/vlsp_tx.sv
module vlsp_tx
   import vlsp_pkg::*;
#(
   parameter int MAG_W = 12,
   parameter int EXT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic             cs_n,
   input  logic             eoc,
   input  fmt_t             fmt,
   input  logic [MAG_W-1:0] mag,
   input  logic             sgn,
   output logic             do_o
);
   localparam int FLD_W = MAG_W + EXT_W;
   localparam int WRD_W = FLD_W + 1;

   logic [MAG_W-1:0] mag_rev, ordered;
   logic [FLD_W-1:0] fld;
   logic [WRD_W-1:0] word, shreg;

   for (genvar g = 0; g < MAG_W; g++) begin : g_rev
      assign mag_rev[g] = mag[MAG_W-1-g];
   end

   assign ordered = fmt.lsb ? mag_rev : mag;

   if (EXT_W > 0) begin : g_ext
      assign fld = (fmt.wide && !fmt.lsb) ? {{EXT_W{1'b0}}, mag} : {ordered, {EXT_W{1'b0}}};
   end else begin : g_noext
      assign fld = ordered;
   end

   assign word = fmt.sign_on ? {sgn, fld} : {fld, 1'b0};
   assign do_o = ~cs_n & eoc & shreg[WRD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shreg <= '0;
      else if (load)   shreg <= word;
      else if (shift)  shreg <= {shreg[WRD_W-2:0], 1'b0};
   end
endmodule

// File: rtl/vlsp_port.sv
module vlsp_port
   import vlsp_pkg::*;
#(
   parameter int MAG_W       = 12,
   parameter int EXT_W       = 4,
   parameter int CH_W        = 3,
   parameter int CONV_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic di,
   output logic do_o,
   output logic eoc,
   output logic desync
);
   localparam int FLD_W = MAG_W + EXT_W;
   localparam int LEN_W = $clog2(FLD_W + 2);

   if (CH_W >= MAG_W) begin : g_bad_ch
      $error("channel field must be narrower than the magnitude");
   end
   if (MAG_W < 8) begin : g_bad_mag
      $error("magnitude must cover the 8-bit instruction");
   end
   if (CONV_CYCLES < 1) begin : g_bad_conv
      $error("conversion time must be at least one clock");
   end

   logic             load, sclk_rise, instr_valid, res_sgn;
   logic [7:0]       instr;
   logic [LEN_W-1:0] cur_len, len_next;
   logic [MAG_W-1:0] res_mag;
   fmt_t             fmt;

   vlsp_frame #(.LEN_W(LEN_W), .RST_LEN(MAG_W + 1)) i_frame (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .di(di),
      .len_in(len_next), .load(load), .sclk_rise(sclk_rise),
      .instr_valid(instr_valid), .instr(instr), .desync(desync), .cur_len(cur_len)
   );

   vlsp_ctrl #(.MAG_W(MAG_W), .EXT_W(EXT_W), .CH_W(CH_W),
               .CONV_CYCLES(CONV_CYCLES), .LEN_W(LEN_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .eoc(eoc), .fmt(fmt), .res_mag(res_mag), .res_sgn(res_sgn), .len_next(len_next)
   );

   vlsp_tx #(.MAG_W(MAG_W), .EXT_W(EXT_W)) i_tx (
      .clk(clk), .rst_n(rst_n), .load(load), .shift(sclk_rise), .cs_n(cs_n),
      .eoc(eoc), .fmt(fmt), .mag(res_mag), .sgn(res_sgn), .do_o(do_o)
   );
endmodule

// File: rtl/vlsp_port_chk.sv
module vlsp_port_chk #(
   parameter int LEN_W = 5,
   parameter int MAG_W = 12,
   parameter int EXT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             do_o,
   input logic             eoc,
   input logic             desync,
   input logic             instr_valid,
   input logic [7:0]       instr,
   input logic [LEN_W-1:0] cur_len
);
   localparam int FLD_W = MAG_W + EXT_W;

   // R3: a converting instruction drops eoc on the next clock
   p_conv_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && instr[7] |=> !eoc);

   // R3: output idle while converting
   p_busy_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc |-> !do_o);

   // R6: configuration instructions leave eoc high
   p_cfg_no_conv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && !instr[7] && eoc |=> eoc);

   // R7: desync never clears
   p_desync_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      desync |=> desync);

   // R5: latched frame length is one of the four legal values
   p_len_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_len == LEN_W'(MAG_W)) || (cur_len == LEN_W'(MAG_W + 1)) ||
      (cur_len == LEN_W'(FLD_W)) || (cur_len == LEN_W'(FLD_W + 1)));

   // R8: output idle while deselected
   p_cs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !do_o);
endmodule

bind vlsp_port vlsp_port_chk #(.LEN_W(LEN_W), .MAG_W(MAG_W), .EXT_W(EXT_W)) i_vlsp_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .do_o(do_o), .eoc(eoc), .desync(desync),
   .instr_valid(instr_valid), .instr(instr), .cur_len(cur_len)
);

// File: tb/test_vlsp_port.sv
`timescale 1ns/1ps
module test_vlsp_port;
   localparam int CONV = 20;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, di = 1'b0;
   logic do_o, eoc, desync;
   int   total = 0, bad = 0;

   // model state
   logic        m_wide = 0, m_lsb = 0, m_sign = 1;
   logic [1:0]  m_acq = 2'd1;
   logic [2:0]  m_chan = 0;
   logic [11:0] m_seq = 0, m_mag = 0;
   logic        m_sgn = 0;

   always #5 clk = ~clk;

   vlsp_port #(.CONV_CYCLES(CONV)) i_vlsp_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .di(di),
      .do_o(do_o), .eoc(eoc), .desync(desync)
   );

   task automatic check(input bit ok, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic int exp_len();
      return (m_wide ? 16 : 12) + int'(m_sign);
   endfunction

   function automatic int acq_tot();
      case (m_acq)
         2'd0: return 6 + CONV;
         2'd1: return 10 + CONV;
         2'd2: return 18 + CONV;
         default: return 34 + CONV;
      endcase
   endfunction

   function automatic logic [16:0] exp_word();
      logic [16:0] w = '0;
      logic [15:0] v = {4'b0000, m_mag};
      int p = 16;
      int wd = m_wide ? 16 : 12;
      if (m_sign) begin w[p] = m_sgn; p--; end
      for (int j = 0; j < wd; j++) begin
         w[p] = v[m_lsb ? j : (wd - 1 - j)];
         p--;
      end
      return w;
   endfunction

   function automatic logic [7:0] conv(input logic wd, input logic ls, input logic [2:0] ch);
      return {1'b1, wd, ls, ch, 2'b00};
   endfunction

   task automatic model_exec(input logic [7:0] ins);
      if (ins[7]) begin
         m_wide = ins[6]; m_lsb = ins[5]; m_chan = ins[4:2]; m_seq = m_seq + 1;
      end else begin
         case (ins[6:4])
            3'b001: m_sign = 1;
            3'b010: m_sign = 0;
            3'b100: m_acq = ins[1:0];
            default: ;
         endcase
      end
   endtask

   task automatic conv_end();
      m_mag = {m_chan, m_seq[8:0]};
      m_sgn = m_seq[0];
   endtask

   task automatic clk_bit(input logic b, output logic o);
      @(negedge clk); o = do_o; di = b; sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
      @(negedge clk);
   endtask

   task automatic cs_low();
      @(negedge clk); cs_n = 1'b0;
      @(negedge clk);
   endtask

   task automatic cs_high();
      @(negedge clk); cs_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] ins, input int nbits, input string tag);
      logic [16:0] ew, got, mask;
      ew = exp_word(); got = '0; mask = '0;
      for (int i = 0; i < nbits; i++) begin
         logic o;
         clk_bit((i < 8) ? ins[7-i] : 1'b0, o);
         got[16-i] = o; mask[16-i] = 1'b1;
         if (i == 7) begin
            model_exec(ins);
            if (ins[7]) begin
               int lowc = 1;
               check(!eoc && !do_o, {tag, " R3 eoc low, DO idle"}, {eoc, do_o}, 0);
               while (!eoc && lowc < 200) begin @(negedge clk); lowc++; end
               check(lowc == acq_tot(), {tag, " R3 eoc low clocks"}, lowc, acq_tot());
               conv_end();
            end else begin
               check(eoc == 1'b1, {tag, " R6 no conversion"}, eoc, 1);
            end
         end
      end
      check(got == (ew & mask), {tag, " R2 R4 DO bits"}, got, ew & mask);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(eoc == 1 && desync == 0 && do_o == 0, "R1 reset outputs", {eoc, desync, do_o}, 3'b100);

      // count-delimited frames
      cs_low();
      xfer(conv(0, 0, 3'd5), 13, "R1 first frame");
      for (int f = 0; f < 4; f++) begin
         for (int s = 0; s < 2; s++) begin
            xfer(s ? 8'h10 : 8'h20, exp_len(), "R6 sign cfg");
            xfer(conv(f[1], f[0], 3'(f * 2 + s)), exp_len(), "R5 conv");
         end
      end
      xfer(8'h00, exp_len(), "R5 readout");
      for (int c = 0; c < 4; c++) begin
         xfer({6'b010000, 2'(c)}, exp_len(), "R6 acq cfg");
         xfer(conv(1, 0, 3'(c)), exp_len(), "R3 acq conv");
      end
      xfer(8'h70, exp_len(), "R6 unknown op");
      xfer(8'h00, exp_len(), "R5 readout2");
      cs_high();
      check(desync == 0, "R7 clean boundary", desync, 0);

      // strobed frames
      cs_low(); xfer(conv(0, 1, 3'd6), 8, "R8 short conv"); cs_high();
      check(do_o == 0, "R8 DO idle while deselected", do_o, 0);
      cs_low(); xfer(8'h00, exp_len(), "R8 readout"); cs_high();
      cs_low(); xfer(conv(1, 1, 3'd2), 5, "R8 partial"); cs_high();
      check(eoc == 1, "R8 partial starts nothing", eoc, 1);
      cs_low(); xfer(8'h00, exp_len(), "R8 after partial"); cs_high();
      check(desync == 0, "R7 strobed no desync", desync, 0);

      // conversion end coinciding with frame start
      begin
         logic [7:0] ins;
         logic o;
         int n;
         ins = conv(0, 0, 3'd7);
         cs_low();
         for (int i = 0; i < 8; i++) clk_bit(ins[7-i], o);
         model_exec(ins);
         n = acq_tot();
         cs_n = 1'b1;
         repeat (n - 2) @(negedge clk);
         cs_n = 1'b0;
         conv_end();
         xfer(8'h00, exp_len(), "R9 same-clock load");
         check(eoc == 1, "R9 eoc back high", eoc, 1);
         cs_high();
      end

      // desync
      cs_low();
      xfer(8'h00, exp_len(), "R7 full");
      xfer(8'h00, 5, "R7 short");
      cs_high();
      check(desync == 1, "R7 desync set", desync, 1);
      cs_low(); xfer(8'h00, exp_len(), "R7 later"); cs_high();
      check(desync == 1, "R7 desync sticky", desync, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule